// File: doc/BRIEF.md
# Wake and Interrupt Event Flags

This block holds a byte of sticky event flags that tell a microcontroller why it woke up or why it was interrupted. Three inputs come from other clock or power domains: a pushbutton, a power-good / PLL-lock level and an autowake timer expiry. Each passes through a synchroniser and an edge detector before it can set a flag. Three more events are single-cycle pulses that are already synchronous: a transfer-busy event and two firmware-collision events. Each raises its own flag.

Firmware reads the flag vector and clears chosen flags by writing zero to their bits. A power-down request to sleep or to LCD-only mode also clears the pushbutton flag. Each flag can reach the interrupt request output only through a per-bit enable.

The power-fall flag needs a qualifier. A power manager that brings the part into its brownout state because of a pushbutton or timer wake raises the `wake_entry` level. A falling power-good edge seen while that level is high does not set the power-fall flag.

Top module: `wake_event_flags`

## Requirements
- R1: After reset, `flags` reads 0x00 and `irq` is low.
- R2: A rising edge on `pb_async` sets `flags[4]`. A falling edge sets nothing.
- R3: A rising edge on `pwr_ok_async` sets `flags[6]`.
- R4: A falling edge on `pwr_ok_async` sets `flags[7]`, but only when `wake_entry` is low in the cycle the edge is detected. When `wake_entry` is high, `flags[7]` is left unchanged.
- R5: A rising edge on `wake_tmr_async` sets `flags[5]`.
- R6: A pulse on `xfer_evt` sets `flags[0]`. A pulse on `col_evt[0]` sets `flags[2]`, and a pulse on `col_evt[1]` sets `flags[3]`.
- R7: A cycle with `wr_en` high clears every flag whose `wr_data` bit is 0. Flags whose bit is 1 are unchanged. `flags[1]` always reads 0.
- R8: A pulse on `sleep_req` or on `lcd_req` clears `flags[4]` and no other flag.
- R9: When a hardware set and a clear (software write or mode request) hit the same flag in the same cycle, the flag ends up set.
- R10: In the default configuration, `irq` is the combinational OR over all bits of `flags & irq_en`.
- R11: A change on an asynchronous input takes effect on the (SYNC_STAGES+1)-th rising clock edge after it. After SYNC_STAGES edges the flag is still clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pb_async | input | 1 | Pushbutton level, asynchronous |
| pwr_ok_async | input | 1 | Power-good / PLL-lock level, asynchronous |
| wake_tmr_async | input | 1 | Autowake timer expiry level, asynchronous |
| xfer_evt | input | 1 | Transfer-busy event pulse |
| col_evt | input | 2 | Firmware-collision event pulses |
| wake_entry | input | 1 | High while brownout was entered through a wake rather than power loss |
| sleep_req | input | 1 | Sleep mode request pulse |
| lcd_req | input | 1 | LCD-only mode request pulse |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 8 | Write data; a 0 bit clears the flag |
| irq_en | input | 8 | Per-flag interrupt enable |
| flags | output | 8 | Sticky flag vector |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the pulse inputs and `wr_en` are synchronous to `clk` and that the asynchronous levels are low while reset is asserted. Without that, the edge detectors would report a rise just after reset. The bench drives every input on the falling clock edge and holds the asynchronous levels low during reset. It leaves each level steady for at least four cycles, so every edge is detected exactly once. The bench sweeps all 256 write patterns and all 256 enable patterns against a fully set flag vector.

// File: rtl/wef_pkg.sv
package wef_pkg;
   localparam int FLAG_W    = 8;
   localparam int B_XFER    = 0;
   localparam int B_COL0    = 2;
   localparam int B_COL1    = 3;
   localparam int B_PB      = 4;
   localparam int B_TMR     = 5;
   localparam int B_PRISE   = 6;
   localparam int B_PFALL   = 7;
   localparam logic [FLAG_W-1:0] USED_MASK = 8'hFD;
   // index of each asynchronous source inside the synchroniser vector
   localparam int A_PB      = 0;
   localparam int A_PWR     = 1;
   localparam int A_TMR     = 2;
   localparam int ASYNC_N   = 3;
endpackage

// File: rtl/wef_sync.sv
module wef_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("wef_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("wef_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d_async;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/wef_edge.sv
module wef_edge #(
   parameter int WIDTH = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] rise,
   output logic [WIDTH-1:0] fall
);
   logic [WIDTH-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= lvl;
   end

   assign rise = lvl & ~prev;
   assign fall = ~lvl & prev;

   for (genvar i = 0; i < WIDTH; i++) begin : g_chk
      // R2: a detected edge is a single-cycle event
      a_r2_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
         rise[i] |=> !rise[i]);
      a_r4_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
         fall[i] |=> !fall[i]);
      a_r2_no_both: assert property (@(posedge clk) disable iff (!rst_n)
         !(rise[i] && fall[i]));
   end
endmodule

// File: rtl/wef_flag_reg.sv
module wef_flag_reg #(
   parameter int               W    = 8,
   parameter logic [W-1:0]     MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("wef_flag_reg: W must be at least 1");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (MASK[i]) begin : g_live
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      r <= 1'b0;
            else if (set[i]) r <= 1'b1;   // set beats clear
            else if (clr[i]) r <= 1'b0;
            else             r <= r;
         end
         assign q[i] = r;

         a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> q[i]);
         a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !q[i]);
         a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr[i] && !set[i]) |=> $stable(q[i]));
      end else begin : g_dead
         assign q[i] = 1'b0;
      end
   end
endmodule

// File: rtl/wake_event_flags.sv
module wake_event_flags
   import wef_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit IRQ_REG     = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pb_async,
   input  logic                pwr_ok_async,
   input  logic                wake_tmr_async,
   input  logic                xfer_evt,
   input  logic [1:0]          col_evt,
   input  logic                wake_entry,
   input  logic                sleep_req,
   input  logic                lcd_req,
   input  logic                wr_en,
   input  logic [FLAG_W-1:0]   wr_data,
   input  logic [FLAG_W-1:0]   irq_en,
   output logic [FLAG_W-1:0]   flags,
   output logic                irq
);
   logic [ASYNC_N-1:0] a_raw, a_sync, a_rise, a_fall;
   logic [FLAG_W-1:0]  hw_set, sw_clr, mode_clr, all_clr;

   assign a_raw[A_PB]  = pb_async;
   assign a_raw[A_PWR] = pwr_ok_async;
   assign a_raw[A_TMR] = wake_tmr_async;

   wef_sync #(.WIDTH(ASYNC_N), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(a_raw), .q_sync(a_sync));

   wef_edge #(.WIDTH(ASYNC_N)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(a_sync), .rise(a_rise), .fall(a_fall));

   always_comb begin
      hw_set          = '0;
      hw_set[B_XFER]  = xfer_evt;
      hw_set[B_COL0]  = col_evt[0];
      hw_set[B_COL1]  = col_evt[1];
      hw_set[B_PB]    = a_rise[A_PB];
      hw_set[B_TMR]   = a_rise[A_TMR];
      hw_set[B_PRISE] = a_rise[A_PWR];
      hw_set[B_PFALL] = a_fall[A_PWR] & ~wake_entry;
   end

   assign sw_clr   = wr_en ? ~wr_data : '0;
   always_comb begin
      mode_clr       = '0;
      mode_clr[B_PB] = sleep_req | lcd_req;
   end
   assign all_clr = sw_clr | mode_clr;

   wef_flag_reg #(.W(FLAG_W), .MASK(USED_MASK)) u_flags (
      .clk(clk), .rst_n(rst_n), .set(hw_set), .clr(all_clr), .q(flags));

   logic irq_c;
   assign irq_c = |(flags & irq_en);

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_c;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_c;
   end

   // R4: a wake-qualified power fall leaves the fall flag alone
   a_r4_fall_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
      (a_fall[A_PWR] && wake_entry && !all_clr[B_PFALL]) |=> $stable(flags[B_PFALL]));
   // R4: an unqualified power fall is recorded
   a_r4_fall_recorded: assert property (@(posedge clk) disable iff (!rst_n)
      (a_fall[A_PWR] && !wake_entry) |=> flags[B_PFALL]);
   // R8: a mode request with no pushbutton edge leaves the pushbutton flag clear
   a_r8_mode_clears_pb: assert property (@(posedge clk) disable iff (!rst_n)
      ((sleep_req || lcd_req) && !a_rise[A_PB]) |=> !flags[B_PB]);
   // R2: the pushbutton flag rises only after a detected pushbutton edge
   a_r2_pb_source: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags[B_PB] && !a_rise[A_PB]) |=> !flags[B_PB]);
endmodule

// File: tb/wake_event_flags_bench.sv
`timescale 1ns/1ps
module wake_event_flags_bench;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       pb_async, pwr_ok_async, wake_tmr_async, xfer_evt;
   logic [1:0] col_evt;
   logic       wake_entry, sleep_req, lcd_req, wr_en;
   logic [7:0] wr_data, irq_en;
   logic [7:0] flags;
   logic       irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   wake_event_flags u_wake_event_flags (
      .clk(clk), .rst_n(rst_n), .pb_async(pb_async), .pwr_ok_async(pwr_ok_async),
      .wake_tmr_async(wake_tmr_async), .xfer_evt(xfer_evt), .col_evt(col_evt),
      .wake_entry(wake_entry), .sleep_req(sleep_req), .lcd_req(lcd_req),
      .wr_en(wr_en), .wr_data(wr_data), .irq_en(irq_en), .flags(flags), .irq(irq));

   task automatic chk8(input logic [7:0] act, input logic [7:0] exp, input string req);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (4) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic write(input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0; wr_data = 8'hFF;
   endtask

   // brings every flag to 1 (0xFD); leaves pb=1, tmr=1, pwr=0
   task automatic set_all();
      @(negedge clk);
      pb_async = 1'b0; wake_tmr_async = 1'b0; pwr_ok_async = 1'b0;
      settle();
      pb_async = 1'b1; wake_tmr_async = 1'b1; pwr_ok_async = 1'b1;
      xfer_evt = 1'b1; col_evt = 2'b11;
      @(negedge clk); xfer_evt = 1'b0; col_evt = 2'b00;
      settle();
      pwr_ok_async = 1'b0;
      settle();
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      pb_async = 0; pwr_ok_async = 0; wake_tmr_async = 0; xfer_evt = 0;
      col_evt = 0; wake_entry = 0; sleep_req = 0; lcd_req = 0;
      wr_en = 0; wr_data = 8'hFF; irq_en = 8'hFF;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk8(flags, 8'h00, "R1 flags in reset");
      chk8({7'd0, irq}, 8'h00, "R1 irq in reset");
      rst_n = 1'b1;
      settle();
      chk8(flags, 8'h00, "R1 flags after reset");

      // R11 + R2: pushbutton latency
      pb_async = 1'b1;
      repeat (2) @(posedge clk); #1;
      chk8(flags, 8'h00, "R11 not yet after SYNC_STAGES edges");
      @(posedge clk); #1;
      chk8(flags, 8'h10, "R11/R2 pushbutton set on third edge");
      write(8'h00);
      pb_async = 1'b0; settle();
      chk8(flags, 8'h00, "R2 falling pushbutton sets nothing");

      // R5 timer
      wake_tmr_async = 1'b1; settle();
      chk8(flags, 8'h20, "R5 wake timer rise");
      write(8'h00);

      // R3 power rise, R4 recorded fall
      pwr_ok_async = 1'b1; settle();
      chk8(flags, 8'h40, "R3 power rise");
      pwr_ok_async = 1'b0; settle();
      chk8(flags, 8'hC0, "R4 power fall recorded");
      write(8'h00);
      chk8(flags, 8'h00, "R7 write zero clears all");

      // R4 suppressed fall
      pwr_ok_async = 1'b1; settle(); write(8'h00);
      wake_entry = 1'b1;
      pwr_ok_async = 1'b0; settle();
      chk8(flags, 8'h00, "R4 wake-qualified fall suppressed");
      wake_entry = 1'b0;

      // R6 pulses, one at a time
      @(negedge clk); xfer_evt = 1'b1; @(negedge clk); xfer_evt = 1'b0;
      chk8(flags, 8'h01, "R6 transfer event");
      @(negedge clk); col_evt = 2'b01; @(negedge clk); col_evt = 2'b00;
      chk8(flags, 8'h05, "R6 collision 0");
      @(negedge clk); col_evt = 2'b10; @(negedge clk); col_evt = 2'b00;
      chk8(flags, 8'h0D, "R6 collision 1");

      // R7 write sweep
      for (int d = 0; d < 256; d++) begin
         set_all();
         chk8(flags, 8'hFD, "R7 all flags set");
         write(d[7:0]);
         chk8(flags, 8'hFD & d[7:0], "R7 write-zero clear sweep");
      end

      // R10 enable sweep with all flags set
      set_all();
      for (int e = 0; e < 256; e++) begin
         @(negedge clk); irq_en = e[7:0]; #1;
         chk8({7'd0, irq}, {7'd0, |(8'hFD & e[7:0])}, "R10 irq enable sweep");
      end
      irq_en = 8'hFF;

      // R8 mode-entry clearing
      set_all();
      @(negedge clk); sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
      chk8(flags, 8'hED, "R8 sleep clears pushbutton only");
      set_all();
      @(negedge clk); lcd_req = 1'b1; @(negedge clk); lcd_req = 1'b0;
      chk8(flags, 8'hED, "R8 lcd clears pushbutton only");

      // R9 set beats software clear
      write(8'h00);
      @(negedge clk); xfer_evt = 1'b1; wr_en = 1'b1; wr_data = 8'h00;
      @(negedge clk); xfer_evt = 1'b0; wr_en = 1'b0; wr_data = 8'hFF;
      chk8(flags, 8'h01, "R9 set wins over write clear");

      // R9 pushbutton edge beats sleep request
      write(8'h00);
      @(negedge clk); pb_async = 1'b0; settle();
      pb_async = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk); sleep_req = 1'b1;
      @(negedge clk); sleep_req = 1'b0;
      chk8(flags, 8'h10, "R9 set wins over mode clear");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule